// File: doc/BRIEF.md
# Descriptor Ring Bus Master Controller

This block walks a small circular ring of 16-byte command descriptors kept in system memory and hands each one, in order, to a bus transaction engine. Software owns a head pointer in the control register and sets a run bit. Hardware fetches descriptors from its own tail pointer up to that head. After each transaction it writes the result fields back into the descriptor, advances the tail, wraps it at the programmed ring size and raises completion or error flags. When the tail reaches the head the controller goes idle.

Software uses a small word-indexed register port. Index 0 holds the ring base byte address, index 1 control, index 2 status, index 3 the ring size and index 4 timing. Read data is registered and appears one cycle after the index is presented. The memory port uses 32-bit words and a request/acknowledge handshake. Descriptor slot `n` occupies the four words starting at `base/4 + 4n`. In descriptor byte order, byte 0 is the target address with R/W, byte 1 the write length or command, byte 2 the read length, byte 3 control, byte 4 status, byte 5 retry, byte 6 received count and byte 7 transmitted count. Bytes 8 to 15 form a 64-bit data pointer, low word first. Bytes are little-endian within each word.

Top module: `dr_ring_ctrl`

## Requirements
- R1: After reset all registers read as zero, `irq` is 0, `eng_start` is 0 and no memory request is made.
- R2: Base (index 0, full 32 bits), control (run bit 0, error-interrupt enable bit 4, head in bits 23:16), size (index 3, bits 7:0) and timing (index 4, bits 31:30) read back as written, with read data valid one cycle after the index. Status (index 2) shows busy in bit 0, error flag in bit 4, done flag in bit 5 and tail in bits 23:16.
- R3: With run set and head different from tail, the controller reads the four words of slot `tail`, then holds `eng_start` high until `eng_done`. While `eng_start` is high it presents bytes 0 to 3 and the 64-bit pointer on the engine outputs.
- R4: On `eng_done` the engine's status, received and transmitted counts are captured. They are written to word 1 of the slot as {tx, rx, retry, status}, with the fetched retry byte kept. The tail advances in the cycle that write is acknowledged.
- R5: The tail advances modulo (size + 1), returning to 0 after slot `size`.
- R6: Descriptors are processed in ring order until tail equals head. The controller then stops, with busy reading 1 during processing and 0 afterwards.
- R7: Every completion sets the done flag. A completion whose status bit 0 (success) is clear also sets the error flag. Writing 1 to status bit 5 or bit 4 clears the corresponding flag.
- R8: `irq` is registered. It equals (done flag AND bit 6 of the last completed descriptor's control byte) OR (error flag AND error-interrupt enable).
- R9: When a completion and a write-1-to-clear of a flag fall on the same clock edge, the flag ends up set.
- R10: With run clear, no new descriptor is started even if head differs from tail. Clearing run while a descriptor is executing lets that descriptor finish and then stops.
- R11: `eng_speed` equals timing bits 31:30 (0 = 80 kHz, 1 = 100 kHz, 2 = 400 kHz, 3 = 1 MHz).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data for the previous cycle's index |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with acknowledge |
| mem_ack | input | 1 | Memory acknowledge |
| eng_start | output | 1 | Descriptor offered to engine, held until done |
| eng_addr_rw | output | 8 | Target address and R/W byte |
| eng_wlen | output | 8 | Write length or command byte |
| eng_rlen | output | 8 | Read length |
| eng_ctrl | output | 8 | Descriptor control byte |
| eng_dptr | output | 64 | Data pointer |
| eng_speed | output | 2 | Bus speed select |
| eng_done | input | 1 | Engine finished the transaction |
| eng_status | input | 8 | Result status byte |
| eng_rxcnt | input | 8 | Bytes received |
| eng_txcnt | input | 8 | Bytes transmitted |
| irq | output | 1 | Interrupt request |

## Verification
The two functions that can meet in one cycle are the hardware setting the done and error flags and a software write-1-to-clear of those same flags. The bench provokes this by pulsing `eng_done` and then issuing a clearing status write in the next cycle. That write lands on exactly the edge where the write-back is acknowledged and the tail advances. It judges the outcome by reading status afterwards and requiring the done flag to be set, then shows that a later lone clear does remove it. Tail wrap, stop on run clear and interrupt gating are exercised as separate directed scenarios.

// File: rtl/dr_pkg.sv
package dr_pkg;
  // register word indices
  localparam logic [2:0] RA_BASE = 3'd0;
  localparam logic [2:0] RA_CTRL = 3'd1;
  localparam logic [2:0] RA_STAT = 3'd2;
  localparam logic [2:0] RA_SIZE = 3'd3;
  localparam logic [2:0] RA_TIME = 3'd4;

  // bit positions
  localparam int B_RUN   = 0;
  localparam int B_EIE   = 4;
  localparam int B_BUSY  = 0;
  localparam int B_EFLG  = 4;
  localparam int B_DFLG  = 5;
  localparam int PTR_LSB = 16;
  localparam int SPD_LSB = 30;
  localparam int DC_IRQ  = 6;
  localparam int DS_OK   = 0;

  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_EXEC, ST_WB} seq_st_t;
endpackage

// File: rtl/dr_regs.sv
module dr_regs import dr_pkg::*; #(
  parameter int PTRW = 8,
  parameter int AW   = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            reg_we,
  input  logic [2:0]      reg_addr,
  input  logic [31:0]     reg_wdata,
  output logic [31:0]     reg_rdata,
  input  logic [PTRW-1:0] tail,
  input  logic            busy,
  input  logic            cpl,
  input  logic            cpl_ok,
  input  logic            cpl_irq,
  output logic            run,
  output logic            err_ie,
  output logic [PTRW-1:0] head,
  output logic [PTRW-1:0] size,
  output logic [AW-1:0]   base_w,
  output logic [1:0]      speed,
  output logic            done_flag,
  output logic            err_flag,
  output logic            irq
);
  logic [31:0] base_q;
  logic        irq_req_q;
  logic [31:0] rd_mux;
  logic        we_base, we_ctrl, we_stat, we_size, we_time;

  assign we_base = reg_we && (reg_addr == RA_BASE);
  assign we_ctrl = reg_we && (reg_addr == RA_CTRL);
  assign we_stat = reg_we && (reg_addr == RA_STAT);
  assign we_size = reg_we && (reg_addr == RA_SIZE);
  assign we_time = reg_we && (reg_addr == RA_TIME);
  assign base_w  = base_q[AW+1:2];

  always_comb begin
    rd_mux = '0;
    case (reg_addr)
      RA_BASE: rd_mux = base_q;
      RA_CTRL: begin
        rd_mux[B_RUN]            = run;
        rd_mux[B_EIE]            = err_ie;
        rd_mux[PTR_LSB +: PTRW]  = head;
      end
      RA_STAT: begin
        rd_mux[B_BUSY]           = busy;
        rd_mux[B_EFLG]           = err_flag;
        rd_mux[B_DFLG]           = done_flag;
        rd_mux[PTR_LSB +: PTRW]  = tail;
      end
      RA_SIZE: rd_mux[PTRW-1:0]  = size;
      RA_TIME: rd_mux[SPD_LSB +: 2] = speed;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q    <= '0;
      run       <= 1'b0;
      err_ie    <= 1'b0;
      head      <= '0;
      size      <= '0;
      speed     <= '0;
      done_flag <= 1'b0;
      err_flag  <= 1'b0;
      irq_req_q <= 1'b0;
      irq       <= 1'b0;
      reg_rdata <= '0;
    end else begin
      if (we_base) base_q <= reg_wdata;
      if (we_ctrl) begin
        run    <= reg_wdata[B_RUN];
        err_ie <= reg_wdata[B_EIE];
        head   <= reg_wdata[PTR_LSB +: PTRW];
      end
      if (we_size) size  <= reg_wdata[PTRW-1:0];
      if (we_time) speed <= reg_wdata[SPD_LSB +: 2];
      // hardware set has priority over software clear
      if (cpl)                               done_flag <= 1'b1;
      else if (we_stat && reg_wdata[B_DFLG]) done_flag <= 1'b0;
      if (cpl && !cpl_ok)                    err_flag  <= 1'b1;
      else if (we_stat && reg_wdata[B_EFLG]) err_flag  <= 1'b0;
      if (cpl) irq_req_q <= cpl_irq;
      irq       <= (done_flag & irq_req_q) | (err_flag & err_ie);
      reg_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/dr_seq.sv
module dr_seq import dr_pkg::*; #(
  parameter int PTRW = 8,
  parameter int AW   = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run,
  input  logic [PTRW-1:0] head,
  input  logic [PTRW-1:0] size,
  input  logic [AW-1:0]   base_w,
  output logic            mem_req,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [31:0]     mem_wdata,
  input  logic [31:0]     mem_rdata,
  input  logic            mem_ack,
  output logic            eng_start,
  output logic [7:0]      eng_addr_rw,
  output logic [7:0]      eng_wlen,
  output logic [7:0]      eng_rlen,
  output logic [7:0]      eng_ctrl,
  output logic [63:0]     eng_dptr,
  input  logic            eng_done,
  input  logic [7:0]      eng_status,
  input  logic [7:0]      eng_rxcnt,
  input  logic [7:0]      eng_txcnt,
  output logic [PTRW-1:0] tail,
  output logic            busy,
  output logic            cpl,
  output logic            cpl_ok,
  output logic            cpl_irq
);
  localparam int WPD = 4;  // words per descriptor
  localparam int WSW = $clog2(WPD);

  seq_st_t         st;
  logic [WSW-1:0]  wsel;
  logic [31:0]     w0, dlo, dhi;
  logic [7:0]      retry, res_st, res_rx, res_tx;
  logic [PTRW-1:0] tail_nx;
  logic [WSW-1:0]  sel;
  logic [AW-1:0]   slot_off;

  assign tail_nx  = (tail >= size) ? '0 : tail + PTRW'(1);
  assign sel      = (st == ST_WB) ? WSW'(1) : wsel;
  assign slot_off = AW'(tail) << WSW;
  assign mem_req  = (st == ST_FETCH) || (st == ST_WB);
  assign mem_we   = (st == ST_WB);
  assign mem_addr = base_w + slot_off + AW'(sel);
  assign mem_wdata = {res_tx, res_rx, retry, res_st};

  assign eng_start   = (st == ST_EXEC);
  assign eng_addr_rw = w0[7:0];
  assign eng_wlen    = w0[15:8];
  assign eng_rlen    = w0[23:16];
  assign eng_ctrl    = w0[31:24];
  assign eng_dptr    = {dhi, dlo};

  assign busy    = (st != ST_IDLE);
  assign cpl     = (st == ST_WB) && mem_ack;
  assign cpl_ok  = res_st[DS_OK];
  assign cpl_irq = w0[24 + DC_IRQ];

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      wsel   <= '0;
      tail   <= '0;
      w0     <= '0;
      dlo    <= '0;
      dhi    <= '0;
      retry  <= '0;
      res_st <= '0;
      res_rx <= '0;
      res_tx <= '0;
    end else begin
      case (st)
        ST_IDLE: if (run && (head != tail)) begin
          st   <= ST_FETCH;
          wsel <= '0;
        end
        ST_FETCH: if (mem_ack) begin
          case (wsel)
            2'd0:    w0    <= mem_rdata;
            2'd1:    retry <= mem_rdata[15:8];
            2'd2:    dlo   <= mem_rdata;
            default: dhi   <= mem_rdata;
          endcase
          if (wsel == WSW'(WPD-1)) st <= ST_EXEC;
          else                     wsel <= wsel + WSW'(1);
        end
        ST_EXEC: if (eng_done) begin
          res_st <= eng_status;
          res_rx <= eng_rxcnt;
          res_tx <= eng_txcnt;
          st     <= ST_WB;
        end
        default: if (mem_ack) begin
          tail <= tail_nx;
          wsel <= '0;
          st   <= (run && (tail_nx != head)) ? ST_FETCH : ST_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/dr_ring_ctrl.sv
module dr_ring_ctrl #(
  parameter int PTRW = 8,
  parameter int AW   = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_we,
  input  logic [2:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata,
  input  logic          mem_ack,
  output logic          eng_start,
  output logic [7:0]    eng_addr_rw,
  output logic [7:0]    eng_wlen,
  output logic [7:0]    eng_rlen,
  output logic [7:0]    eng_ctrl,
  output logic [63:0]   eng_dptr,
  output logic [1:0]    eng_speed,
  input  logic          eng_done,
  input  logic [7:0]    eng_status,
  input  logic [7:0]    eng_rxcnt,
  input  logic [7:0]    eng_txcnt,
  output logic          irq
);
  logic [PTRW-1:0] tail, head, size;
  logic [AW-1:0]   base_w;
  logic            busy, cpl, cpl_ok, cpl_irq;
  logic            run, err_ie, done_flag, err_flag;

  dr_regs #(.PTRW(PTRW), .AW(AW)) u_regs (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tail(tail), .busy(busy),
    .cpl(cpl), .cpl_ok(cpl_ok), .cpl_irq(cpl_irq), .run(run), .err_ie(err_ie),
    .head(head), .size(size), .base_w(base_w), .speed(eng_speed),
    .done_flag(done_flag), .err_flag(err_flag), .irq(irq)
  );

  dr_seq #(.PTRW(PTRW), .AW(AW)) u_seq (
    .clk(clk), .rst(rst), .run(run), .head(head), .size(size), .base_w(base_w),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .eng_start(eng_start), .eng_addr_rw(eng_addr_rw), .eng_wlen(eng_wlen),
    .eng_rlen(eng_rlen), .eng_ctrl(eng_ctrl), .eng_dptr(eng_dptr),
    .eng_done(eng_done), .eng_status(eng_status), .eng_rxcnt(eng_rxcnt),
    .eng_txcnt(eng_txcnt), .tail(tail), .busy(busy), .cpl(cpl),
    .cpl_ok(cpl_ok), .cpl_irq(cpl_irq)
  );
endmodule

// File: rtl/dr_ring_chk.sv
module dr_ring_chk #(
  parameter int PTRW = 8,
  parameter int AW   = 16
) (
  input logic            clk,
  input logic            rst,
  input logic            mem_req,
  input logic            mem_we,
  input logic            mem_ack,
  input logic [AW-1:0]   mem_addr,
  input logic            eng_start,
  input logic            eng_done,
  input logic            irq,
  input logic [PTRW-1:0] tail,
  input logic            busy,
  input logic            run,
  input logic            done_flag,
  input logic            err_flag
);
  // R3: memory request and address held until acknowledged
  p_mem_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

  // R3: engine request held until done
  p_eng_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (eng_start && !eng_done) |=> eng_start);

  // R4: tail only moves on an acknowledged write-back
  p_tail_after_wb_r4: assert property (@(posedge clk) disable iff (rst)
    !$stable(tail) |-> $past(mem_req && mem_we && mem_ack));

  // R6: engine is only offered work while busy
  p_engine_busy_r6: assert property (@(posedge clk) disable iff (rst)
    eng_start |-> busy);

  // R8: interrupt only follows a raised flag
  p_irq_cause_r8: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(done_flag || err_flag));

  // R10: an idle controller with run clear stays idle
  p_no_start_r10: assert property (@(posedge clk) disable iff (rst)
    (!busy && !run) |=> !busy);
endmodule

bind dr_ring_ctrl dr_ring_chk #(.PTRW(PTRW), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .mem_req(mem_req), .mem_we(mem_we), .mem_ack(mem_ack),
  .mem_addr(mem_addr), .eng_start(eng_start), .eng_done(eng_done), .irq(irq),
  .tail(tail), .busy(busy), .run(run), .done_flag(done_flag), .err_flag(err_flag)
);

// File: tb/dr_ring_ctrl_test.sv
`timescale 1ns/1ps
module dr_ring_ctrl_test;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          reg_we = 1'b0;
  logic [2:0]    reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic          mem_req, mem_we, mem_ack;
  logic [AW-1:0] mem_addr;
  logic [31:0]   mem_wdata, mem_rdata;
  logic          eng_start;
  logic [7:0]    eng_addr_rw, eng_wlen, eng_rlen, eng_ctrl;
  logic [63:0]   eng_dptr;
  logic [1:0]    eng_speed;
  logic          eng_done = 1'b0;
  logic [7:0]    eng_status = '0, eng_rxcnt = '0, eng_txcnt = '0;
  logic          irq;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  logic [31:0] mem [64];

  always #4 clk = ~clk;

  assign mem_ack   = mem_req;
  assign mem_rdata = mem[mem_addr[5:0]];
  always @(posedge clk) if (mem_req && mem_we) mem[mem_addr[5:0]] <= mem_wdata;

  dr_ring_ctrl #(.PTRW(8), .AW(AW)) uut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack), .eng_start(eng_start),
    .eng_addr_rw(eng_addr_rw), .eng_wlen(eng_wlen), .eng_rlen(eng_rlen),
    .eng_ctrl(eng_ctrl), .eng_dptr(eng_dptr), .eng_speed(eng_speed),
    .eng_done(eng_done), .eng_status(eng_status), .eng_rxcnt(eng_rxcnt),
    .eng_txcnt(eng_txcnt), .irq(irq)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // all tasks are entered and left at a falling edge
  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    @(posedge clk); @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_eng(input string tag, input logic [7:0] a, input logic [7:0] wl,
                          input logic [7:0] rl, input logic [7:0] c, input logic [63:0] p);
    for (int i = 0; i < 60 && !eng_start; i++) @(negedge clk);
    check({tag, " R3 eng_start"}, eng_start, 1);
    check({tag, " R3 addr_rw"}, eng_addr_rw, a);
    check({tag, " R3 wlen"}, eng_wlen, wl);
    check({tag, " R3 rlen"}, eng_rlen, rl);
    check({tag, " R3 ctrl"}, eng_ctrl, c);
    check({tag, " R3 dptr"}, eng_dptr, p);
  endtask

  task automatic finish_eng(input logic [7:0] s, input logic [7:0] rx, input logic [7:0] tx);
    eng_done = 1'b1; eng_status = s; eng_rxcnt = rx; eng_txcnt = tx;
    @(posedge clk); @(negedge clk);
    eng_done = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), d);
      check($sformatf("R1 reg %0d after reset", a), d, 0);
    end
    check("R1 irq after reset", irq, 0);
    check("R1 eng_start after reset", eng_start, 0);
    check("R1 mem_req after reset", mem_req, 0);
  endtask

  task automatic t_regs;
    logic [31:0] d;
    wr(3'd0, 32'h0000_0040); rd(3'd0, d); check("R2 base readback", d, 32'h40);
    wr(3'd3, 32'h0000_0003); rd(3'd3, d); check("R2 size readback", d, 32'h3);
    wr(3'd4, 32'h8000_0000); rd(3'd4, d); check("R2 timing readback", d, 32'h8000_0000);
    check("R11 speed select", eng_speed, 2'd2);
    wr(3'd1, 32'h0000_0010); rd(3'd1, d); check("R2 control readback", d, 32'h10);
    idle(10);
    check("R10 no start with run clear", eng_start, 0);
  endtask

  task automatic t_single;
    logic [31:0] d;
    wr(3'd1, 32'h0001_0011);
    wait_eng("single", 8'hA4, 8'h03, 8'h01, 8'h40, 64'h0000_0001_DEAD_0000);
    finish_eng(8'h01, 8'h01, 8'h03);
    idle(3);
    check("R4 writeback word", mem[6'h11], 32'h0301_2201);
    rd(3'd2, d); check("R7 status after success", d, 32'h0001_0020);
    check("R8 irq from requested completion", irq, 1);
    wr(3'd2, 32'h0000_0020); idle(1);
    check("R8 irq after done cleared", irq, 0);
    rd(3'd2, d); check("R7 done cleared by write 1", d, 32'h0001_0000);
  endtask

  task automatic t_wrap;
    logic [31:0] d;
    wr(3'd1, 32'h0000_0011);
    wait_eng("slot1", 8'h11, 8'h00, 8'h00, 8'h00, 64'h0);
    rd(3'd2, d); check("R6 busy while executing", d[0], 1);
    finish_eng(8'h01, 8'h00, 8'h00);
    wait_eng("slot2", 8'h12, 8'h00, 8'h00, 8'h00, 64'h0);
    finish_eng(8'h01, 8'h00, 8'h00);
    wait_eng("slot3", 8'h13, 8'h00, 8'h00, 8'h00, 64'h0);
    finish_eng(8'h01, 8'h00, 8'h00);
    idle(3);
    rd(3'd2, d); check("R5 tail wrapped to 0, R6 idle", d, 32'h0000_0020);
    check("R8 no irq when not requested", irq, 0);
    wr(3'd2, 32'h0000_0020);
  endtask

  task automatic t_error;
    logic [31:0] d;
    mem[6'h10] = 32'h0000_0030;
    wr(3'd1, 32'h0001_0011);
    wait_eng("err", 8'h30, 8'h00, 8'h00, 8'h00, 64'h0000_0001_DEAD_0000);
    finish_eng(8'h08, 8'h00, 8'h01);
    idle(3);
    rd(3'd2, d); check("R7 error flag set on failed status", d, 32'h0001_0030);
    check("R8 irq from error with enable", irq, 1);
    wr(3'd1, 32'h0001_0001); idle(1);
    check("R8 irq gated by error enable", irq, 0);
    wr(3'd2, 32'h0000_0030);
    rd(3'd2, d); check("R7 both flags cleared", d, 32'h0001_0000);
  endtask

  task automatic t_stop;
    logic [31:0] d;
    wr(3'd1, 32'h0003_0000);
    idle(20);
    check("R10 no fetch with run clear", eng_start, 0);
    rd(3'd2, d); check("R10 tail unchanged", d, 32'h0001_0000);
    wr(3'd1, 32'h0003_0001);
    wait_eng("stop", 8'h11, 8'h00, 8'h00, 8'h00, 64'h0);
    wr(3'd1, 32'h0003_0000);
    finish_eng(8'h01, 8'h00, 8'h00);
    idle(10);
    check("R10 no further descriptor", eng_start, 0);
    rd(3'd2, d); check("R10 stopped after one", d, 32'h0002_0020);
    wr(3'd2, 32'h0000_0030);
  endtask

  task automatic t_collide;
    logic [31:0] d;
    wr(3'd1, 32'h0003_0001);
    wait_eng("collide", 8'h12, 8'h00, 8'h00, 8'h00, 64'h0);
    finish_eng(8'h01, 8'h00, 8'h00);
    wr(3'd2, 32'h0000_0030);  // lands on the write-back edge
    idle(2);
    rd(3'd2, d); check("R9 set wins over same-edge clear", d, 32'h0003_0020);
    wr(3'd2, 32'h0000_0020);
    rd(3'd2, d); check("R7 later clear works", d, 32'h0003_0000);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = '0;
    mem[6'h10] = 32'h4001_03A4;
    mem[6'h11] = 32'h0000_2200;
    mem[6'h12] = 32'hDEAD_0000;
    mem[6'h13] = 32'h0000_0001;
    for (int n = 1; n < 4; n++) mem[6'h10 + 4*n] = 32'h10 + n;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_regs();
    t_single();
    t_wrap();
    t_error();
    t_stop();
    t_collide();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule